// File: doc/BRIEF.md
# Byte-Parity Cache Data Array Checker

This block wraps a small cache data array with byte-granular parity. Each data word is split into byte lanes, and every lane stores one even-parity bit next to it. A write regenerates parity only for the lanes it enables. Every read compares the stored parity bits with parity recomputed from the stored data. A mismatch on any lane produces a one-cycle abort request and sets a sticky fault flag at bit 10 of a 32-bit fault status word. Software clears that flag by writing a one to it.

The abort is imprecise. The word being read is always returned, even when its check fails, so the requester is not stalled and the faulty data does reach it. A tag array sits alongside the data and shares its write and read addresses. The tags carry no parity and never take part in the check. A test input can invert one chosen stored parity bit, which lets a bench plant a fault in any lane of any word.

Top module: `dcache_parity_guard`

## Requirements
- R1: After reset, `rd_valid`, `abort_o` and every bit of `fsr_o` are 0, and every word reads back as zero with no abort.
- R2: A read requested with `rd_en` at one rising edge presents `rd_valid`=1, `rd_data` and `rd_tag` after that edge, for exactly one cycle.
- R3: A write with all byte enables set stores the whole word and its even parity (each lane's bit equals the XOR of that byte). A later read returns the word with `abort_o`=0.
- R4: On a partial write, only the lanes whose `wr_be` bit is set change. Lane i is bits [8i+7:8i], so lane 0 is bits 7:0. The other lanes keep both their data and their stored parity.
- R5: `inj_en` inverts the stored parity bit of lane `inj_lane` in word `inj_addr`. The next read of that word raises `abort_o`. A second injection into the same lane restores clean parity.
- R6: A read that fails its check still returns the stored data unchanged on `rd_data`, with `rd_valid`=1 in the same cycle as `abort_o`.
- R7: A failing read sets `fsr_o[10]` at the same edge that raises `abort_o`, so the flag already reads 1 while the abort is high. All other `fsr_o` bits stay 0.
- R8: `fsr_o[10]` is sticky. It is cleared only by `fsr_clr_en` with `fsr_clr_mask[10]`=1; a clear mask without bit 10 leaves it set. A detected error in the same cycle as a clear wins, and the flag stays 1.
- R9: A new error while `fsr_o[10]` is already set still produces an abort pulse.
- R10: Rewriting a lane with its enable set regenerates that lane's parity and removes an injected fault there. Writing only other lanes leaves the fault in place.
- R11: With `tag_we` set, `tag_wdata` is written to the tag of word `wr_addr`, independently of `wr_en`. Tags are returned on `rd_tag` and never cause an abort.
- R12: `abort_o` is high for exactly one cycle per failing read and is never high without `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | AW | Word address for data and tag writes |
| wr_be | input | NB | Byte-lane enables, bit i for lane i |
| wr_data | input | DATA_W | Write data |
| tag_we | input | 1 | Tag write strobe |
| tag_wdata | input | TAG_W | Tag write value |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_data | output | DATA_W | Read data, returned even on a parity failure |
| rd_tag | output | TAG_W | Tag of the word read, unchecked |
| abort_o | output | 1 | One-cycle abort request on a parity mismatch |
| fsr_clr_en | input | 1 | Fault status write-one-to-clear strobe |
| fsr_clr_mask | input | FSR_W | Bits to clear in the fault status |
| fsr_o | output | FSR_W | Fault status word, fault flag at bit 10 |
| inj_en | input | 1 | Test: invert one stored parity bit |
| inj_addr | input | AW | Test: word holding the bit to invert |
| inj_lane | input | LW | Test: lane whose parity bit is inverted |

## Verification
The bench builds the block with 32-bit words, 8-bit lanes, a depth of 8 and 12-bit tags. Four lanes make every lane index in the 2-bit `inj_lane` field reachable, and they allow mixed enable patterns such as alternating lanes. The small depth keeps every word within a short directed sequence. The bench keeps its own model of the data, the tags and a per-word set of corrupted lanes. It also covers faults that persist across partial rewrites, double injection, and the cycle where an error and a clear collide.

// File: rtl/dcpg_pkg.sv
package dcpg_pkg;
  localparam int FSR_W     = 32;
  localparam int FAULT_BIT = 10;

  function automatic logic [FSR_W-1:0] fault_flag_mask();
    return FSR_W'(1) << FAULT_BIT;
  endfunction
endpackage

// File: rtl/dcpg_lane_parity.sv
module dcpg_lane_parity #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [NB-1:0]     par_o
);
  function automatic logic [NB-1:0] even_lanes(input logic [DATA_W-1:0] w);
    logic [NB-1:0] p;
    for (int i = 0; i < NB; i++) p[i] = ^w[i*BYTE_W +: BYTE_W];
    return p;
  endfunction

  assign par_o = even_lanes(word_i);
endmodule

// File: rtl/dcpg_store.sv
module dcpg_store #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 20,
  localparam int NB = DATA_W / BYTE_W,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NB-1:0]     wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_par,
  input  logic              tag_we,
  input  logic [TAG_W-1:0]  tag_wdata,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [LW-1:0]     inj_lane,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] arr_word_o,
  output logic [NB-1:0]     arr_par_o,
  output logic [DATA_W-1:0] rd_data_q,
  output logic [TAG_W-1:0]  rd_tag_q,
  output logic              rd_valid_q
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [NB-1:0]     par_mem  [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];

  // Unregistered view of the addressed word, used by the parity compare
  assign arr_word_o = data_mem[rd_addr];
  assign arr_par_o  = par_mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) begin
        data_mem[d] <= '0;
        par_mem[d]  <= '0;
        tag_mem[d]  <= '0;
      end
      rd_data_q  <= '0;
      rd_tag_q   <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) begin
        rd_data_q <= data_mem[rd_addr];
        rd_tag_q  <= tag_mem[rd_addr];
      end
      if (tag_we) tag_mem[wr_addr] <= tag_wdata;
      for (int d = 0; d < DEPTH; d++) begin
        for (int b = 0; b < NB; b++) begin
          if (wr_en && wr_addr == AW'(d) && wr_be[b]) begin
            data_mem[d][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
            par_mem[d][b] <= wr_par[b] ^
                             (inj_en && inj_addr == AW'(d) && inj_lane == LW'(b));
          end else if (inj_en && inj_addr == AW'(d) && inj_lane == LW'(b)) begin
            par_mem[d][b] <= ~par_mem[d][b];
          end
        end
      end
    end
  end

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid_q);
  a_r2_valid_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid_q);
endmodule

// File: rtl/dcpg_check.sv
module dcpg_check #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [NB-1:0] stored_par,
  input  logic [NB-1:0] regen_par,
  output logic [NB-1:0] lane_err,
  output logic          err_now,
  output logic          abort_q
);
  assign lane_err = stored_par ^ regen_par;
  assign err_now  = rd_en && (lane_err != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= err_now;
  end

  // R5: a bad lane seen at a read request yields an abort on the next cycle
  a_r5_lane_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $countones(lane_err) > 0) |=> abort_q);
  // R12: no abort follows a cycle without a read request
  a_r12_abort_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !abort_q);
endmodule

// File: rtl/dcpg_fault_reg.sv
module dcpg_fault_reg
  import dcpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_en,
  input  logic [FSR_W-1:0] clr_mask,
  output logic             fault_q,
  output logic [FSR_W-1:0] fsr_o
);
  logic clr_hit;
  assign clr_hit = clr_en && clr_mask[FAULT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_q <= 1'b0;
    else if (set_i)   fault_q <= 1'b1;
    else if (clr_hit) fault_q <= 1'b0;
  end

  assign fsr_o = fault_q ? fault_flag_mask() : '0;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr_hit) |=> fault_q);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> fault_q);
  a_r8_clear_only_by_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_q && !set_i) |=> !fault_q);
endmodule

// File: rtl/dcache_parity_guard.sv
module dcache_parity_guard
  import dcpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 20,
  localparam int NB = DATA_W / BYTE_W,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NB-1:0]     wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_we,
  input  logic [TAG_W-1:0]  tag_wdata,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              abort_o,
  input  logic              fsr_clr_en,
  input  logic [FSR_W-1:0]  fsr_clr_mask,
  output logic [FSR_W-1:0]  fsr_o,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [LW-1:0]     inj_lane
);
  logic [NB-1:0]     wr_par, regen_par, arr_par, lane_err;
  logic [DATA_W-1:0] arr_word;
  logic              err_now, fault_q;

  dcpg_lane_parity #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wr_gen (
    .word_i(wr_data), .par_o(wr_par));

  dcpg_lane_parity #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd_gen (
    .word_i(arr_word), .par_o(regen_par));

  dcpg_store #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .wr_par(wr_par),
    .tag_we(tag_we), .tag_wdata(tag_wdata),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_lane(inj_lane),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_word_o(arr_word), .arr_par_o(arr_par),
    .rd_data_q(rd_data), .rd_tag_q(rd_tag), .rd_valid_q(rd_valid));

  dcpg_check #(.NB(NB)) u_check (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
    .stored_par(arr_par), .regen_par(regen_par),
    .lane_err(lane_err), .err_now(err_now), .abort_q(abort_o));

  dcpg_fault_reg u_fsr (
    .clk(clk), .rst_n(rst_n), .set_i(err_now),
    .clr_en(fsr_clr_en), .clr_mask(fsr_clr_mask),
    .fault_q(fault_q), .fsr_o(fsr_o));

  // R6: an abort always comes with the returned data
  a_r6_abort_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> rd_valid);
  // R7: the fault flag is already visible while the abort is high
  a_r7_fault_visible: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> fsr_o[FAULT_BIT]);
  a_r7_fault_tracks_reg: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $countones(fsr_o) == 1);
  // R12: one pulse per failing read
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_o && !$past(err_now, 1) ) |-> 1'b0);
endmodule

// File: tb/dcache_parity_guard_tb.sv
module dcache_parity_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int DEPTH  = 8;
  localparam int TAG_W  = 12;
  localparam int NB = 4;
  localparam int AW = 3;
  localparam int LW = 2;
  localparam logic [31:0] FLAG = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, tag_we = 1'b0, rd_en = 1'b0, fsr_clr_en = 1'b0, inj_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [NB-1:0] wr_be = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [TAG_W-1:0] tag_wdata = '0;
  logic [31:0] fsr_clr_mask = '0;
  logic [LW-1:0] inj_lane = '0;
  logic rd_valid, abort_o;
  logic [DATA_W-1:0] rd_data;
  logic [TAG_W-1:0] rd_tag;
  logic [31:0] fsr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DATA_W-1:0] m_data [DEPTH];
  logic [TAG_W-1:0]  m_tag  [DEPTH];
  logic [NB-1:0]     m_bad  [DEPTH];
  logic              m_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_parity_guard #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .tag_we(tag_we), .tag_wdata(tag_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag), .abort_o(abort_o),
    .fsr_clr_en(fsr_clr_en), .fsr_clr_mask(fsr_clr_mask), .fsr_o(fsr_o),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_lane(inj_lane));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DATA_W-1:0] d, input logic [NB-1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
    for (int b = 0; b < NB; b++) if (be[b]) begin
      m_data[a][b*8 +: 8] = d[b*8 +: 8];
      m_bad[a][b] = 1'b0;
    end
  endtask

  task automatic do_tag(input logic [AW-1:0] a, input logic [TAG_W-1:0] t);
    @(negedge clk);
    tag_we = 1'b1; wr_addr = a; tag_wdata = t;
    @(negedge clk);
    tag_we = 1'b0;
    m_tag[a] = t;
  endtask

  task automatic do_inject(input logic [AW-1:0] a, input logic [LW-1:0] l);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_lane = l;
    @(negedge clk);
    inj_en = 1'b0;
    m_bad[a][l] = ~m_bad[a][l];
  endtask

  // Read one word, check the result cycle and the cycle after it
  task automatic do_read(input string req, input logic [AW-1:0] a);
    logic exp_abort;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    exp_abort = (m_bad[a] != '0);
    if (exp_abort) m_fault = 1'b1;
    chk(req, "rd_valid", 64'(rd_valid), 64'd1);
    chk(req, "rd_data", 64'(rd_data), 64'(m_data[a]));
    chk(req, "rd_tag", 64'(rd_tag), 64'(m_tag[a]));
    chk(req, "abort", 64'(abort_o), 64'(exp_abort));
    chk(req, "fsr", 64'(fsr_o), m_fault ? 64'(FLAG) : 64'd0);
    @(negedge clk);
    chk("R12", "abort after pulse", 64'(abort_o), 64'd0);
    chk("R2", "rd_valid after read", 64'(rd_valid), 64'd0);
  endtask

  task automatic do_clear(input string req, input logic [31:0] mask);
    @(negedge clk);
    fsr_clr_en = 1'b1; fsr_clr_mask = mask;
    @(negedge clk);
    fsr_clr_en = 1'b0; fsr_clr_mask = '0;
    if (mask[10]) m_fault = 1'b0;
    chk(req, "fsr after clear", 64'(fsr_o), m_fault ? 64'(FLAG) : 64'd0);
  endtask

  task automatic t_reset();
    chk("R1", "rd_valid", 64'(rd_valid), 64'd0);
    chk("R1", "abort", 64'(abort_o), 64'd0);
    chk("R1", "fsr", 64'(fsr_o), 64'd0);
    do_read("R1", 3'd6);
  endtask

  task automatic t_full_words();
    do_write(3'd1, 32'hA5C3_0F81, 4'hF);
    do_read("R3", 3'd1);
    do_write(3'd0, 32'hFFFF_FFFF, 4'hF);
    do_write(3'd3, 32'h0102_0408, 4'hF);
    do_read("R3", 3'd0);
    do_read("R2", 3'd3);
  endtask

  task automatic t_partial();
    do_write(3'd2, 32'h1122_3344, 4'hF);
    do_write(3'd2, 32'hAABB_CCDD, 4'b0101);
    chk("R4", "model merge", 64'(m_data[2]), 64'h11BB_33DD);
    do_read("R4", 3'd2);
    do_write(3'd2, 32'h7700_0000, 4'b1000);
    do_read("R4", 3'd2);
  endtask

  task automatic t_inject();
    do_inject(3'd2, 2'd1);
    do_read("R5", 3'd2);      // abort with data returned (R6), flag set (R7)
    chk("R6", "data kept", 64'(m_data[2]), 64'h77BB_33DD);
    do_inject(3'd3, 2'd3);
    do_inject(3'd3, 2'd3);
    do_clear("R8", FLAG);
    do_read("R5", 3'd3);      // double injection restores clean parity
  endtask

  task automatic t_sticky();
    do_read("R7", 3'd2);
    do_clear("R8", 32'hFFFF_FBFF);   // every bit except the flag
    do_clear("R8", 32'h0000_0001);
    do_read("R9", 3'd2);             // error while set still pulses
    do_clear("R8", FLAG);
    // Error and clear in the same cycle: set wins
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd2; fsr_clr_en = 1'b1; fsr_clr_mask = FLAG;
    @(negedge clk);
    rd_en = 1'b0; fsr_clr_en = 1'b0; fsr_clr_mask = '0;
    m_fault = 1'b1;
    chk("R8", "set beats clear abort", 64'(abort_o), 64'd1);
    chk("R8", "set beats clear fsr", 64'(fsr_o), 64'(FLAG));
    do_clear("R8", FLAG);
  endtask

  task automatic t_repair();
    do_write(3'd2, 32'h0000_0099, 4'b0001);   // other lane: fault stays
    do_read("R10", 3'd2);
    do_clear("R10", FLAG);
    do_write(3'd2, 32'h0000_5A00, 4'b0010);   // rewrite faulty lane
    do_read("R10", 3'd2);
  endtask

  task automatic t_tags();
    do_write(3'd5, 32'hDEAD_BEEF, 4'hF);
    do_tag(3'd5, 12'hABC);
    do_read("R11", 3'd5);
    do_tag(3'd5, 12'h001);
    do_read("R11", 3'd5);
    do_tag(3'd7, 12'hFFF);
    do_read("R11", 3'd7);
  endtask

  initial begin
    for (int d = 0; d < DEPTH; d++) begin
      m_data[d] = '0; m_tag[d] = '0; m_bad[d] = '0;
    end
    m_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_words();
    t_partial();
    t_inject();
    t_sticky();
    t_repair();
    t_tags();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule